// File: doc/BRIEF.md
# I2C Master STOP Sequencer

This block generates the STOP condition at the end of an I2C master transfer and checks for lost arbitration while it does so. It controls the two open-drain lines through active-high pull-down enables and reads the real line levels back. When a STOP is requested, the block holds SCL low and pulls SDA low. Once SDA reads low it lets SCL go. It then waits for SCL to read high, which lets a slave stretch the clock for as long as it needs. After one baud period of setup time it lets SDA go, and one baud period later it reads SDA to confirm that the STOP took place.

The baud period comes from an internal down-counter. The counter is loaded from a 7-bit reload value and runs down to its timeout. A reload of zero counts as one. A clean STOP sets a sticky done flag. Two events show that another master is holding a line low: SDA reads low at the final check, or SCL reads low after it was released and before the sequence ends. Either event sets a sticky collision flag, releases both lines and drops the busy bit. A clear strobe resets both flags. The line-level inputs must already be synchronised to `clk` when they reach the block.

Top module: `i2c_stop_gen`

## Requirements
- R1: After reset, both pull-down enables are 0 and `stop_busy`, `done_flag` and `coll_flag` are 0.
- R2: A `stop_req` pulse is accepted while `stop_busy` and `coll_flag` are both 0. On the next cycle `stop_busy` is 1 and both `sda_oe` and `scl_oe` are 1 (line pulled low).
- R3: SCL is released (`scl_oe` falls) only on a cycle after SDA has read low. `sda_oe` stays 1 when this happens.
- R4: While a slave holds SCL low after it has been released, SDA stays pulled low and no timeout advances the sequence.
- R5: `sda_oe` falls on the (N+1)-th rising clock edge after the first cycle in which `scl_in` reads 1. N is the effective reload value.
- R6: N edges after SDA is released, if SDA reads 1, `done_flag` sets and `stop_busy` clears, with `coll_flag` left at 0.
- R7: If SDA reads 0 at that final check, `coll_flag` sets, `stop_busy` clears, `done_flag` stays 0 and both enables are 0.
- R8: If SCL reads 0 at any time after it first read 1 and before the sequence ends, then on the next edge `coll_flag` sets, `stop_busy` clears and both enables go to 0.
- R9: `done_flag` and `coll_flag` hold their value until a `clr_flags` strobe clears them on the next edge.
- R10: A `stop_req` arriving while `coll_flag` is 1 is ignored: `stop_busy` stays 0 and SDA is not pulled low.
- R11: A reload value of 0 acts as N = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req | input | 1 | Single-cycle request to start a STOP |
| clr_flags | input | 1 | Strobe that clears the done and collision flags |
| reload | input | 7 | Baud period in clocks (0 acts as 1) |
| sda_in | input | 1 | Synchronised SDA line level |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| stop_busy | output | 1 | STOP in progress; clears on completion or collision |
| done_flag | output | 1 | Sticky: STOP completed cleanly |
| coll_flag | output | 1 | Sticky: bus collision seen |

## Verification
A sequencer stuck in the wrong state shows up at the enables within one edge. If it leaves the pull too early, SCL rises before SDA is low. If it leaves the pull too late, SDA stays low after a STOP should have ended. A counter that loads or reloads wrongly shows up as an SDA release or a done flag that lands off by whole baud periods. The bench counts edges from the first cycle SCL reads high, so a slip of even one cycle is reported. A broken collision path shows up on the next edge as a line still driven, or a flag missing, after the bench pulls a line low.

// File: rtl/i2cstop_pkg.sv
package i2cstop_pkg;

    localparam int BAUD_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PULL_SDA = 3'd1,
        ST_FREE_SCL = 3'd2,
        ST_SETUP    = 3'd3,
        ST_FREE_SDA = 3'd4
    } stop_state_e;

    typedef struct packed {
        logic sda_oe;
        logic scl_oe;
    } line_drive_t;

    typedef struct packed {
        logic done_ev;
        logic coll_ev;
    } stop_event_t;

    function automatic line_drive_t drive_for(stop_state_e s);
        line_drive_t d;
        d.sda_oe = (s == ST_PULL_SDA) || (s == ST_FREE_SCL) || (s == ST_SETUP);
        d.scl_oe = (s == ST_PULL_SDA);
        return d;
    endfunction

endpackage

// File: rtl/i2cstop_baud.sv
module i2cstop_baud #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] reload,
    output logic         tmo
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic [W-1:0] eff;

    assign eff = (reload == '0) ? ONE : reload;
    assign tmo = (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= eff;
        else if (cnt != '0)
            cnt <= cnt - ONE;
    end

    // R11: a load never leaves the counter idle at zero
    assert_load_nonzero_R11: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt != '0);
    // R5: the count falls by one each cycle while it runs
    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && !load) |=> cnt == $past(cnt) - ONE);
endmodule

// File: rtl/i2cstop_flags.sv
module i2cstop_flags
    import i2cstop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stop_req,
    input  logic        clr_flags,
    input  stop_event_t ev,
    output logic        accept,
    output logic        busy,
    output logic        done_flag,
    output logic        coll_flag
);
    assign accept = stop_req && !busy && !coll_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done_flag <= 1'b0;
            coll_flag <= 1'b0;
        end else begin
            if (clr_flags) begin
                done_flag <= 1'b0;
                coll_flag <= 1'b0;
            end
            if (ev.done_ev) done_flag <= 1'b1;
            if (ev.coll_ev) coll_flag <= 1'b1;
            if (accept)
                busy <= 1'b1;
            else if (ev.done_ev || ev.coll_ev)
                busy <= 1'b0;
        end
    end

    // R7: a collision leaves no STOP running
    assert_coll_idle_R7: assert property (@(posedge clk) disable iff (rst)
        coll_flag |-> !busy);
    // R6: done appears only as a running STOP ends
    assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $fell(busy));
    // R10: with the collision flag held, no STOP starts
    assert_req_blocked_R10: assert property (@(posedge clk) disable iff (rst)
        (coll_flag && !clr_flags) |=> !busy);
    // R9: flags stay set without a clear strobe
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !clr_flags) |=> done_flag);
endmodule

// File: rtl/i2cstop_seq.sv
module i2cstop_seq
    import i2cstop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic        sda_in,
    input  logic        scl_in,
    input  logic        tmo,
    output logic        load,
    output line_drive_t drv,
    output stop_event_t ev
);
    stop_state_e state, state_nx;

    always_comb begin
        state_nx   = state;
        load       = 1'b0;
        ev.done_ev = 1'b0;
        ev.coll_ev = 1'b0;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_PULL_SDA;
            ST_PULL_SDA: if (!sda_in) state_nx = ST_FREE_SCL;
            ST_FREE_SCL: if (scl_in) begin
                state_nx = ST_SETUP;
                load     = 1'b1;
            end
            ST_SETUP: begin
                if (!scl_in) begin
                    ev.coll_ev = 1'b1;
                    state_nx   = ST_IDLE;
                end else if (tmo) begin
                    state_nx = ST_FREE_SDA;
                    load     = 1'b1;
                end
            end
            ST_FREE_SDA: begin
                if (!scl_in) begin
                    ev.coll_ev = 1'b1;
                    state_nx   = ST_IDLE;
                end else if (tmo) begin
                    state_nx = ST_IDLE;
                    if (sda_in) ev.done_ev = 1'b1;
                    else        ev.coll_ev = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign drv = drive_for(state);

    // R3: SCL is let go only after SDA was seen low
    assert_scl_after_sda_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(drv.scl_oe) |-> (drv.sda_oe && !$past(sda_in)));
    // R5: SDA is let go in a running STOP only at a baud timeout
    assert_sda_release_tmo_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(drv.sda_oe) && state == ST_FREE_SDA) |-> $past(tmo));
    // R8: after a collision both lines are free
    assert_coll_release_R8: assert property (@(posedge clk) disable iff (rst)
        ev.coll_ev |=> (!drv.sda_oe && !drv.scl_oe));
    // R4: while SCL is still low after release, SDA stays pulled
    assert_stretch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FREE_SCL && !scl_in) |=> drv.sda_oe);
endmodule

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen
    import i2cstop_pkg::*;
#(
    parameter int RELOAD_W = BAUD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stop_req,
    input  logic                clr_flags,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                sda_in,
    input  logic                scl_in,
    output logic                sda_oe,
    output logic                scl_oe,
    output logic                stop_busy,
    output logic                done_flag,
    output logic                coll_flag
);
    logic        accept, load, tmo;
    line_drive_t drv;
    stop_event_t ev;

    i2cstop_flags u_flags (
        .clk(clk), .rst(rst), .stop_req(stop_req), .clr_flags(clr_flags),
        .ev(ev), .accept(accept), .busy(stop_busy),
        .done_flag(done_flag), .coll_flag(coll_flag)
    );

    i2cstop_seq u_seq (
        .clk(clk), .rst(rst), .accept(accept), .sda_in(sda_in),
        .scl_in(scl_in), .tmo(tmo), .load(load), .drv(drv), .ev(ev)
    );

    i2cstop_baud #(.W(RELOAD_W)) u_baud (
        .clk(clk), .rst(rst), .load(load), .reload(reload), .tmo(tmo)
    );

    assign sda_oe = drv.sda_oe;
    assign scl_oe = drv.scl_oe;

    // R2: an accepted request drives both lines low on the next cycle
    assert_start_drive_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (stop_busy && sda_oe && scl_oe));
    // R1: with no STOP running, no line is pulled
    assert_idle_free_R1: assert property (@(posedge clk) disable iff (rst)
        !stop_busy |-> (!sda_oe && !scl_oe));
endmodule

// File: tb/i2c_stop_gen_tb_top.sv
module i2c_stop_gen_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 1'b0, clr_flags = 1'b0;
    logic [6:0] reload = 7'd0;
    logic sda_oe, scl_oe, stop_busy, done_flag, coll_flag;
    logic slave_hold = 1'b0, other_scl = 1'b0, other_sda = 1'b0;
    logic sda_in, scl_in;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign sda_in = !(sda_oe || other_sda);
    assign scl_in = !(scl_oe || slave_hold || other_scl);

    i2c_stop_gen dut_i (
        .clk(clk), .rst(rst), .stop_req(stop_req), .clr_flags(clr_flags),
        .reload(reload), .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe),
        .scl_oe(scl_oe), .stop_busy(stop_busy), .done_flag(done_flag),
        .coll_flag(coll_flag)
    );

    function automatic int eff_n(int r);
        return (r == 0) ? 1 : r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flags();
        clr_flags = 1'b1;
        step();
        clr_flags = 1'b0;
        chk(!done_flag && !coll_flag, "R9", "flags after clear",
            {done_flag, coll_flag}, 0);
    endtask

    // mode 0 clean, 1 SDA held by other master, 2 SCL pulled in setup,
    // 3 SCL pulled after SDA release
    task automatic run_stop(input int r, input int stretch, input int mode);
        int n = eff_n(r);
        int edges;
        reload = 7'(r);
        other_sda = (mode == 1);
        slave_hold = (stretch > 0);
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
        chk(stop_busy && sda_oe && scl_oe, "R2", "busy/sda_oe/scl_oe",
            {stop_busy, sda_oe, scl_oe}, 7);
        step();
        chk(!scl_oe && sda_oe, "R3", "scl released with sda held",
            {scl_oe, sda_oe}, 1);
        for (int i = 0; i < stretch; i++) begin
            step();
            chk(sda_oe && !done_flag, "R4", "sda held while stretched",
                sda_oe, 1);
        end
        slave_hold = 1'b0;
        if (mode == 2) begin
            step();
            other_scl = 1'b1;
            step();
            chk(coll_flag && !stop_busy && !sda_oe && !scl_oe, "R8",
                "scl low in setup", {coll_flag, stop_busy, sda_oe, scl_oe}, 8);
            other_scl = 1'b0;
            return;
        end
        edges = 0;
        while (sda_oe && edges < 300) begin
            step();
            edges++;
        end
        chk(edges == n + 1, (r == 0) ? "R11" : "R5", "edges to sda release",
            edges, n + 1);
        if (mode == 3) begin
            other_scl = 1'b1;
            step();
            chk(coll_flag && !stop_busy && !sda_oe && !scl_oe && !done_flag,
                "R8", "scl low after sda release",
                {coll_flag, stop_busy, sda_oe, scl_oe, done_flag}, 16);
            other_scl = 1'b0;
            return;
        end
        edges = 0;
        while (stop_busy && edges < 300) begin
            step();
            edges++;
        end
        chk(edges == n, "R6", "edges from sda release to end", edges, n);
        if (mode == 0)
            chk(done_flag && !coll_flag, "R6", "done vs coll",
                {done_flag, coll_flag}, 2);
        else
            chk(coll_flag && !done_flag && !sda_oe && !scl_oe, "R7",
                "sda low at final check",
                {coll_flag, done_flag, sda_oe, scl_oe}, 8);
        other_sda = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) step();
        rst = 1'b0;
        step();
        chk(!sda_oe && !scl_oe && !stop_busy && !done_flag && !coll_flag,
            "R1", "reset outputs",
            {sda_oe, scl_oe, stop_busy, done_flag, coll_flag}, 0);

        run_stop(4, 0, 0);
        repeat (5) step();
        chk(done_flag, "R9", "done sticky", done_flag, 1);
        clear_flags();

        run_stop(0, 0, 0);
        clear_flags();
        run_stop(3, 6, 0);
        clear_flags();

        run_stop(5, 2, 1);
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(!stop_busy && !sda_oe, "R10", "request ignored on collision",
                {stop_busy, sda_oe}, 0);
            step();
        end
        chk(coll_flag, "R9", "coll sticky", coll_flag, 1);
        clear_flags();

        run_stop(6, 1, 2);
        clear_flags();
        run_stop(1, 0, 3);
        clear_flags();

        for (int k = 0; k < 30; k++) begin
            int r = $urandom_range(0, 40);
            int s = $urandom_range(0, 4);
            int m = $urandom_range(0, 3);
            if (m == 2 && r < 3) r = 3;
            run_stop(r, s, m);
            repeat ($urandom_range(0, 3)) step();
            clear_flags();
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(1_000_000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule